// File: doc/BRIEF.md
# Host Bus Ownership Arbiter

This block decides who drives the host bus: the CPU or the system controller side. When a PCI or ISA master asks for the bus, the block raises a bus-hold request to the CPU. It waits for the CPU's hold acknowledge and only then grants the new master. When the master withdraws its request, the block drops both the grant and the hold request. The CPU takes the bus back when its acknowledge falls. While the acknowledge is low the CPU owns the host bus, and the controller remains master of PCI and of the bridge link.

A second, independent path drives an address-hold output. This output makes the CPU float only its address lines, starting in the next clock. Three request lines compete for it: soft reset, a bridge-link transfer and a deturbo request. A fixed priority picks one cause, which is latched and held until that cause's own request drops. When the cause is a bridge transfer, a one-clock start pulse goes to the transfer engine in the clock after address hold rises.

All inputs and outputs are plain level control signals. No data moves through the block, so no stream handshake is needed.

Top module: `host_bus_arbiter`

## Requirements
- R1: During and directly after hard reset, `bus_hold`, `addr_hold`, `master_gnt` and `xfer_start` are low and `hold_cause` is 0.
- R2: From idle, a high `master_req` raises `bus_hold` at the next clock edge, and `bus_hold` stays high while the request stands and the acknowledge is pending.
- R3: `master_gnt` rises only at the clock edge after `cpu_hlda` is seen high with `bus_hold` asserted and `master_req` still high, and it is never high while `cpu_hlda` is low.
- R4: If `master_req` falls before `cpu_hlda` arrives, `bus_hold` falls at the next edge and no grant is issued.
- R5: When a granted master drops `master_req`, `master_gnt` and `bus_hold` both fall at the next edge. No new `bus_hold` is raised until `cpu_hlda` has gone low.
- R6: `bus_owner` reports 0 (CPU) while `cpu_hlda` is low, 2 (granted master) while `master_gnt` is high, and 1 (controller holds the bus, no master granted) otherwise.
- R7: From an idle address-hold path, any high request among `srst_req`, `xfer_req` and `dturbo_req` raises `addr_hold` at the next edge.
- R8: `hold_cause` encodes the winner as 1 for soft reset, 2 for bridge transfer and 3 for deturbo. Priority is soft reset, then bridge transfer, then deturbo.
- R9: `xfer_start` is a one-clock pulse in the clock after `addr_hold` first rises, and only when `hold_cause` is 2.
- R10: While `addr_hold` is high, `hold_cause` does not change, and changes on the other request lines are ignored. `addr_hold` falls at the edge after the latched cause's request goes low. If other requests remain, it rises again one edge later with the new winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| cpu_hlda | input | 1 | CPU hold acknowledge |
| master_req | input | 1 | PCI/ISA master wants the host bus |
| srst_req | input | 1 | Soft reset needs address hold |
| xfer_req | input | 1 | Bridge-link transfer needs address hold |
| dturbo_req | input | 1 | Deturbo needs address hold |
| bus_hold | output | 1 | Bus-hold request to the CPU |
| addr_hold | output | 1 | Address-hold to the CPU |
| master_gnt | output | 1 | Grant to the PCI/ISA master |
| xfer_start | output | 1 | Bridge transfer start pulse |
| hold_cause | output | 2 | Latched address-hold cause (0 none) |
| bus_owner | output | 2 | Current host bus owner |

## Verification
`bus_hold`, `master_gnt` and `addr_hold` are registered, so each changes one edge after the input that causes it. `xfer_start` comes two edges after the address-hold request. `bus_owner` follows `cpu_hlda` in the same cycle. The bench drives every input on the falling edge and checks each registered output at the falling edge after the edge where it is due. It checks `bus_owner` one time unit after the acknowledge changes. All seven non-empty address-hold request combinations are swept, and the hold handshake is run with acknowledge delays of zero to three cycles.

// File: rtl/hba_pkg.sv
package hba_pkg;
  localparam int CAUSE_W = 2;
  localparam int OWNER_W = 2;

  typedef enum logic [CAUSE_W-1:0] {
    C_NONE   = 2'd0,
    C_SRST   = 2'd1,
    C_XFER   = 2'd2,
    C_DTURBO = 2'd3
  } cause_e;

  typedef enum logic [OWNER_W-1:0] {
    OWN_CPU    = 2'd0,
    OWN_CTRL   = 2'd1,
    OWN_MASTER = 2'd2
  } owner_e;

  function automatic cause_e pick_cause(input logic s, input logic x, input logic d);
    if (s)      return C_SRST;
    else if (x) return C_XFER;
    else if (d) return C_DTURBO;
    else        return C_NONE;
  endfunction
endpackage

// File: rtl/hold_fsm.sv
module hold_fsm
  import hba_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_hlda,
  input  logic master_req,
  output logic bus_hold,
  output logic master_gnt,
  output logic [OWNER_W-1:0] bus_owner
);
  typedef enum logic [1:0] {H_IDLE, H_REQ, H_GNT, H_REL} hstate_e;
  hstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      H_IDLE: if (master_req) state_d = H_REQ;
      H_REQ: begin
        if (!master_req)   state_d = H_IDLE;
        else if (cpu_hlda) state_d = H_GNT;
      end
      H_GNT: begin
        if (!master_req)    state_d = H_REL;
        else if (!cpu_hlda) state_d = H_REQ;
      end
      H_REL: if (!cpu_hlda) state_d = H_IDLE;
      default: state_d = H_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= H_IDLE;
    else        state_q <= state_d;
  end

  assign bus_hold   = (state_q == H_REQ) || (state_q == H_GNT);
  assign master_gnt = (state_q == H_GNT) && cpu_hlda;

  always_comb begin
    if (!cpu_hlda)       bus_owner = OWN_CPU;
    else if (master_gnt) bus_owner = OWN_MASTER;
    else                 bus_owner = OWN_CTRL;
  end

  // R2
  hold_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == H_IDLE && master_req) |=> bus_hold);
  // R3
  gnt_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_gnt) |-> ($past(bus_hold) && $past(cpu_hlda)));
  // R4
  withdraw_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == H_REQ && !master_req) |=> (!bus_hold && !master_gnt));
  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_gnt && !master_req) |=> (!bus_hold && !master_gnt));
  // R5
  no_rehold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == H_REL && cpu_hlda) |=> !bus_hold);
endmodule

// File: rtl/ahold_ctl.sv
module ahold_ctl
  import hba_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic srst_req,
  input  logic xfer_req,
  input  logic dturbo_req,
  output logic addr_hold,
  output logic xfer_start,
  output logic [CAUSE_W-1:0] hold_cause
);
  cause_e cause_q;
  logic   busy_q, entered_q, start_q;
  logic   any_req, cause_live;

  assign any_req = srst_req | xfer_req | dturbo_req;

  always_comb begin
    unique case (cause_q)
      C_SRST:   cause_live = srst_req;
      C_XFER:   cause_live = xfer_req;
      C_DTURBO: cause_live = dturbo_req;
      default:  cause_live = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cause_q   <= C_NONE;
      entered_q <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      entered_q <= !busy_q && any_req;
      start_q   <= entered_q && (cause_q == C_XFER);
      if (!busy_q && any_req) begin
        busy_q  <= 1'b1;
        cause_q <= pick_cause(srst_req, xfer_req, dturbo_req);
      end else if (busy_q && !cause_live) begin
        busy_q  <= 1'b0;
        cause_q <= C_NONE;
      end
    end
  end

  assign addr_hold  = busy_q;
  assign xfer_start = start_q;
  assign hold_cause = cause_q;

  // R7
  ahold_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_hold && any_req) |=> addr_hold);
  // R10
  cause_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hold && $past(addr_hold)) |-> $stable(hold_cause));
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (addr_hold && $past(addr_hold) && hold_cause == C_XFER));
  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
endmodule

// File: rtl/host_bus_arbiter.sv
module host_bus_arbiter
  import hba_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_hlda,
  input  logic master_req,
  input  logic srst_req,
  input  logic xfer_req,
  input  logic dturbo_req,
  output logic bus_hold,
  output logic addr_hold,
  output logic master_gnt,
  output logic xfer_start,
  output logic [CAUSE_W-1:0] hold_cause,
  output logic [OWNER_W-1:0] bus_owner
);
  hold_fsm u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_hlda   (cpu_hlda),
    .master_req (master_req),
    .bus_hold   (bus_hold),
    .master_gnt (master_gnt),
    .bus_owner  (bus_owner)
  );

  ahold_ctl u_ahold (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst_req   (srst_req),
    .xfer_req   (xfer_req),
    .dturbo_req (dturbo_req),
    .addr_hold  (addr_hold),
    .xfer_start (xfer_start),
    .hold_cause (hold_cause)
  );

  // R3
  gnt_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_gnt |-> (cpu_hlda && bus_hold));
endmodule

// File: tb/sim_host_bus_arbiter.sv
module sim_host_bus_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_hlda = 1'b0, master_req = 1'b0;
  logic srst_req = 1'b0, xfer_req = 1'b0, dturbo_req = 1'b0;
  logic bus_hold, addr_hold, master_gnt, xfer_start;
  logic [1:0] hold_cause, bus_owner;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_bus_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .cpu_hlda(cpu_hlda), .master_req(master_req),
    .srst_req(srst_req), .xfer_req(xfer_req), .dturbo_req(dturbo_req),
    .bus_hold(bus_hold), .addr_hold(addr_hold), .master_gnt(master_gnt),
    .xfer_start(xfer_start), .hold_cause(hold_cause), .bus_owner(bus_owner)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int prio(input int m);
    if (m[0]) return 1;
    if (m[1]) return 2;
    if (m[2]) return 3;
    return 0;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 bus_hold", bus_hold, 0);
    chk("R1 addr_hold", addr_hold, 0);
    chk("R1 master_gnt", master_gnt, 0);
    chk("R1 xfer_start", xfer_start, 0);
    chk("R1 hold_cause", hold_cause, 0);
    rst_n = 1'b1;
    step();
    chk("R1 bus_hold after reset", bus_hold, 0);

    // Hold handshake with acknowledge delays 0..3
    for (int d = 0; d < 4; d++) begin
      master_req = 1'b1;
      step();
      chk("R2 bus_hold raised", bus_hold, 1);
      chk("R6 owner cpu", bus_owner, 0);
      for (int k = 0; k < d; k++) begin
        step();
        chk("R2 bus_hold held", bus_hold, 1);
        chk("R3 no gnt before ack", master_gnt, 0);
      end
      cpu_hlda = 1'b1;
      #1;
      chk("R6 owner ctrl", bus_owner, 1);
      chk("R3 gnt not early", master_gnt, 0);
      step();
      chk("R3 gnt", master_gnt, 1);
      chk("R6 owner master", bus_owner, 2);
      master_req = 1'b0;
      step();
      chk("R5 gnt dropped", master_gnt, 0);
      chk("R5 hold dropped", bus_hold, 0);
      chk("R6 owner ctrl after release", bus_owner, 1);
      master_req = 1'b1;
      step();
      chk("R5 no rehold while hlda", bus_hold, 0);
      chk("R5 no gnt while released", master_gnt, 0);
      cpu_hlda = 1'b0;
      #1;
      chk("R6 owner cpu back", bus_owner, 0);
      step();
      chk("R5 idle after hlda low", bus_hold, 0);
      step();
      chk("R2 rehold", bus_hold, 1);
      // R4 withdraw before acknowledge
      master_req = 1'b0;
      step();
      chk("R4 hold released", bus_hold, 0);
      chk("R4 no gnt", master_gnt, 0);
      step();
      chk("R4 stays idle", master_gnt, 0);
    end

    // R3 acknowledge without a request gives no grant
    cpu_hlda = 1'b1;
    step();
    chk("R3 no gnt without req", master_gnt, 0);
    chk("R2 no hold without req", bus_hold, 0);
    cpu_hlda = 1'b0;
    step();

    // Address-hold sweep over all request combinations
    for (int m = 1; m < 8; m++) begin
      int c;
      c = prio(m);
      srst_req = m[0]; xfer_req = m[1]; dturbo_req = m[2];
      step();
      chk("R7 addr_hold raised", addr_hold, 1);
      chk("R8 cause", hold_cause, c);
      chk("R9 no start yet", xfer_start, 0);
      step();
      chk("R9 start pulse", xfer_start, (c == 2) ? 1 : 0);
      // flip the non-winning lines
      srst_req   = (c == 1) ? 1'b1 : ~srst_req;
      xfer_req   = (c == 2) ? 1'b1 : ~xfer_req;
      dturbo_req = (c == 3) ? 1'b1 : ~dturbo_req;
      step();
      chk("R9 pulse single", xfer_start, 0);
      chk("R10 cause stable", hold_cause, c);
      chk("R10 hold stays", addr_hold, 1);
      srst_req = 1'b0; xfer_req = 1'b0; dturbo_req = 1'b0;
      step();
      chk("R10 addr_hold released", addr_hold, 0);
      chk("R10 cause cleared", hold_cause, 0);
      step();
      chk("R10 stays idle", addr_hold, 0);
    end

    // R10 re-arbitration when a lower request remains
    srst_req = 1'b1; dturbo_req = 1'b1;
    step();
    chk("R8 srst wins", hold_cause, 1);
    srst_req = 1'b0;
    step();
    chk("R10 gap cycle", addr_hold, 0);
    step();
    chk("R10 rehold", addr_hold, 1);
    chk("R10 new cause", hold_cause, 3);
    dturbo_req = 1'b0;
    step();
    chk("R10 final release", addr_hold, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule